// File: doc/BRIEF.md
# Conditional Relative Jump Unit

This block keeps the program counter for a 16-bit instruction set that addresses a 20-bit byte space. Each cycle it may be offered one instruction word with a valid strobe, together with the current negative (N), zero (Z), carry (C) and overflow (V) status flags. The block checks whether the word is a conditional jump and whether its condition holds against the flags. If the jump is taken, the block loads the relative target into the PC. Otherwise it steps the PC forward by one word.

The block only reads the flags and has no path that writes them. A jump therefore leaves the status flags as they were. The taken flag and the jump-detected flag are registered alongside the PC. Each describes the instruction accepted on the previous clock edge. Fetch, decode of other formats and memory access are left to neighbouring logic.

Top module: `cond_jump_unit`

## Requirements
- R1: A synchronous reset loads the PC with RESET_ADDR (with bit 0 forced to 0) and drives both jump_taken and jump_seen to 0.
- R2: An accepted word is a jump only when instr[15:13] == 3'b001. jump_seen is 1 in the cycle after such a word is accepted, and 0 otherwise. A word with any other opcode never loads a target, whatever its lower bits are.
- R3: The condition field is instr[12:10]. The codes are: 000 taken when Z=0; 001 taken when Z=1; 010 taken when C=0; 011 taken when C=1; 100 taken when N=1; 111 always taken.
- R4: Code 101 is taken when N XOR V is 0 (signed greater-or-equal). Code 110 is taken when N XOR V is 1 (signed less-than).
- R5: When a jump is taken, the next PC is PC + 2 + 2*sext(instr[9:0]). This reaches -511 to +512 words relative to the jump's own address, and jump_taken is 1 in the following cycle.
- R6: All PC arithmetic wraps modulo 2^20, in both directions.
- R7: An accepted non-jump word, or a jump whose condition fails, advances the PC by 2 and leaves jump_taken at 0.
- R8: While instr_valid is low, the PC holds its value and jump_taken and jump_seen read 0 on the next cycle.
- R9: Bit 0 of the PC is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | instr holds a word to act on this cycle |
| instr | input | 16 | Instruction word |
| flag_n | input | 1 | Negative status flag |
| flag_z | input | 1 | Zero status flag |
| flag_c | input | 1 | Carry status flag |
| flag_v | input | 1 | Overflow status flag |
| pc | output | 20 | Program counter (byte address, even) |
| jump_taken | output | 1 | Previous accepted word was a taken jump |
| jump_seen | output | 1 | Previous accepted word was a jump |

## Verification
Every condition code is driven once with flags that satisfy it and once with flags that defeat it. This separates a swapped or inverted condition from a correct one. The signed codes are tried with all four N/V pairs, which shows whether the check uses XOR or one flag alone.

Offsets of +511 and -512 words check the sign extension and the doubling at both ends. Jumps near the top and bottom of the address space expose any arithmetic that does not wrap. Non-jump opcodes that carry an always-taken condition field show whether the opcode gate works, and idle cycles confirm that the PC holds.

// File: rtl/cond_jump_unit.sv
module cond_jump_unit #(
  parameter int                ADDR_W     = 20,
  parameter int                OFF_W      = 10,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [15:0]       instr,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  output logic [ADDR_W-1:0] pc,
  output logic              jump_taken,
  output logic              jump_seen
);

  localparam logic [2:0]        JUMP_OP  = 3'b001;
  localparam logic [ADDR_W-1:0] WORD     = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] RST_EVEN = {RESET_ADDR[ADDR_W-1:1], 1'b0};
  localparam int                EXT_W    = ADDR_W - OFF_W - 1;

  localparam logic [2:0] CC_NZ = 3'b000;
  localparam logic [2:0] CC_Z  = 3'b001;
  localparam logic [2:0] CC_NC = 3'b010;
  localparam logic [2:0] CC_C  = 3'b011;
  localparam logic [2:0] CC_N  = 3'b100;
  localparam logic [2:0] CC_GE = 3'b101;
  localparam logic [2:0] CC_LT = 3'b110;

  logic              is_jump;
  logic              cond_met;
  logic              take;
  logic [OFF_W-1:0]  offset;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] target;

  assign is_jump = instr[15:13] == JUMP_OP;
  assign offset  = instr[OFF_W-1:0];
  assign seq_pc  = pc + WORD;
  assign target  = seq_pc + {{EXT_W{offset[OFF_W-1]}}, offset, 1'b0};
  assign take    = instr_valid && is_jump && cond_met;

  always_comb begin
    case (instr[12:10])
      CC_NZ:   cond_met = !flag_z;
      CC_Z:    cond_met = flag_z;
      CC_NC:   cond_met = !flag_c;
      CC_C:    cond_met = flag_c;
      CC_N:    cond_met = flag_n;
      CC_GE:   cond_met = !(flag_n ^ flag_v);
      CC_LT:   cond_met = flag_n ^ flag_v;
      default: cond_met = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= RST_EVEN;
      jump_taken <= 1'b0;
      jump_seen  <= 1'b0;
    end else begin
      jump_taken <= take;
      jump_seen  <= instr_valid && is_jump;
      if (take)             pc <= target;
      else if (instr_valid) pc <= seq_pc;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc == RST_EVEN && !jump_taken && !jump_seen));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> ($stable(pc) && !jump_taken && !jump_seen));

  // R7
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !is_jump) |=> (pc == $past(pc) + WORD && !jump_taken));

  // R3
  always_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && is_jump && instr[12:10] == 3'b111) |=> (jump_taken && jump_seen));

  // R2
  taken_is_jump_chk: assert property (@(posedge clk) disable iff (rst)
    jump_taken |-> jump_seen);

  // R9
  even_pc_chk: assert property (@(posedge clk) disable iff (rst)
    !pc[0]);

endmodule

// File: tb/test_cond_jump_unit.sv
module test_cond_jump_unit;

  localparam logic [19:0] RST_PC = 20'hFFFF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
  logic [19:0] pc;
  logic        jump_taken, jump_seen;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;

  logic [19:0] q_pc[$];
  logic        q_tk[$];
  logic        q_sn[$];
  string       q_tag[$];
  logic [19:0] model_pc;

  cond_jump_unit #(.RESET_ADDR(RST_PC)) i_cond_jump_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .pc(pc), .jump_taken(jump_taken), .jump_seen(jump_seen));

  always #5 clk = ~clk;

  function automatic logic cond_ok(input logic [2:0] cc, input logic n, z, c, v);
    if (cc == 3'd0) return z == 1'b0;
    if (cc == 3'd1) return z == 1'b1;
    if (cc == 3'd2) return c == 1'b0;
    if (cc == 3'd3) return c == 1'b1;
    if (cc == 3'd4) return n == 1'b1;
    if (cc == 3'd5) return n == v;
    if (cc == 3'd6) return n != v;
    return 1'b1;
  endfunction

  task automatic drive(input logic r, input logic vld, input logic [15:0] w,
                       input logic [3:0] nzcv, input string tag);
    logic jmp, tk;
    int   so;
    @(negedge clk);
    rst = r; instr_valid = vld; instr = w;
    {flag_n, flag_z, flag_c, flag_v} = nzcv;
    if (r) begin
      model_pc = RST_PC; jmp = 0; tk = 0;
    end else if (!vld) begin
      jmp = 0; tk = 0;
    end else begin
      jmp = (w[15:13] == 3'b001);
      tk  = jmp && cond_ok(w[12:10], nzcv[3], nzcv[2], nzcv[1], nzcv[0]);
      so  = (int'(w[9:0]) >= 512) ? int'(w[9:0]) - 1024 : int'(w[9:0]);
      if (tk) model_pc = 20'((int'(model_pc) + 2 + 2 * so) & 32'hFFFFF);
      else    model_pc = 20'((int'(model_pc) + 2) & 32'hFFFFF);
    end
    q_pc.push_back(model_pc); q_tk.push_back(tk); q_sn.push_back(jmp); q_tag.push_back(tag);
  endtask

  function automatic logic [15:0] jw(input logic [2:0] cc, input logic [9:0] off);
    return {3'b001, cc, off};
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_pc.size() > 0) begin
        logic [19:0] ep; logic et, es; string tg;
        ep = q_pc.pop_front(); et = q_tk.pop_front(); es = q_sn.pop_front(); tg = q_tag.pop_front();
        checks++;
        if (pc !== ep || jump_taken !== et || jump_seen !== es || pc[0] !== 1'b0) begin
          errors++;
          $display("FAIL %s: pc=%h taken=%b seen=%b expected pc=%h taken=%b seen=%b",
                   tg, pc, jump_taken, jump_seen, ep, et, es);
        end
      end
    end
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++; checks++;
        $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    model_pc = RST_PC;
    drive(1, 0, 16'h0, 4'b0000, "R1 reset");
    drive(1, 0, 16'h0, 4'b0000, "R1 reset");
    drive(0, 1, 16'h4000, 4'b0000, "R7 non-jump step");
    drive(0, 0, 16'h2FFF, 4'b1111, "R8 idle hold");
    drive(0, 0, 16'h0, 4'b0000, "R8 idle hold");
    drive(0, 1, 16'h7C05, 4'b0000, "R2 opcode 011 with cond 111");
    drive(0, 1, 16'h1C05, 4'b0000, "R2 opcode 000 with cond 111");
    drive(0, 1, 16'hFC05, 4'b0000, "R2 opcode 111 with cond 111");
    for (int n = 0; n < 2; n++)
      for (int z = 0; z < 2; z++)
        for (int c = 0; c < 2; c++)
          for (int v = 0; v < 2; v++)
            for (int cc = 0; cc < 8; cc++) begin
              string tg;
              tg = (cc == 5 || cc == 6) ? "R4 signed cond" : "R3 cond code";
              drive(0, 1, jw(3'(cc), 10'd3), {1'(n), 1'(z), 1'(c), 1'(v)}, tg);
            end
    drive(0, 1, jw(3'b111, 10'h1FF), 4'b0000, "R5 max forward +511");
    drive(0, 1, jw(3'b111, 10'h200), 4'b0000, "R5 max backward -512");
    drive(0, 1, jw(3'b111, 10'h3FF), 4'b0000, "R5 offset -1 word");
    drive(0, 1, jw(3'b001, 10'h1FF), 4'b0000, "R7 failed cond steps");
    drive(1, 0, 16'h0, 4'b0000, "R1 mid reset");
    drive(0, 1, jw(3'b111, 10'h010), 4'b0000, "R6 forward wrap");
    drive(0, 1, jw(3'b111, 10'h200), 4'b0000, "R6 backward wrap");
    drive(0, 1, jw(3'b111, 10'h1FF), 4'b0000, "R6 forward wrap back");
    for (int k = 0; k < 12; k++)
      drive(0, 1, 16'h4321, 4'b1111, "R7 sequential wrap");
    drive(0, 1, jw(3'b110, 10'h3F0), 4'b1000, "R4 lt taken");
    drive(0, 1, jw(3'b101, 10'h3F0), 4'b1000, "R4 ge not taken");
    drive(0, 0, 16'h0, 4'b0000, "R8 idle after jump");
    drive(0, 0, 16'h0, 4'b0000, "R9 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule